// File: doc/BRIEF.md
# Byte-Serial Accumulator Sequencer

This block is the control unit of a very small 8-bit accumulator machine. It runs one instruction at a time and never overlaps two. Each instruction starts with a read of one opcode byte from a synchronous memory port at the program counter. That byte is copied into an instruction register, and memory keeps its contents. Once the opcode is decoded, the block reads whatever operand bytes the opcode needs from the next consecutive addresses. It then executes the instruction and starts the next fetch.

The machine state is an accumulator, a general register, a carry flag, a 16-bit program counter and a sticky flag that marks an unknown opcode. Five opcodes are understood, and an instruction is one, two or three bytes long:

| Opcode | Length | Action |
|---|---|---|
| 0x4F | 1 byte | Copy the accumulator into the general register. |
| 0x37 | 1 byte | Set the carry flag. |
| 0xE6 | 2 bytes | AND the next byte into the accumulator. |
| 0x3E | 2 bytes | Load the next byte into the accumulator. |
| 0x32 | 3 bytes | Write the accumulator to the 16-bit address given by the next two bytes. |

The sequencer moves through these states:

| State | What happens |
|---|---|
| ST_FETCH | Issues the opcode read. |
| ST_FETCH_WAIT | Waits for the read data and loads the instruction register. |
| ST_DECODE | Works out how many operand bytes the opcode needs. |
| ST_OPND | Issues one operand read. |
| ST_OPND_WAIT | Latches that operand byte. |
| ST_EXEC | Changes the registers or performs the memory write. |

The transitions between the states are:

- FETCH to FETCH_WAIT, always.
- FETCH_WAIT to DECODE, always.
- DECODE to OPND when the opcode takes operands, otherwise DECODE to EXEC.
- OPND to OPND_WAIT, always.
- OPND_WAIT back to OPND while more operand bytes remain, otherwise OPND_WAIT to EXEC.
- EXEC to FETCH, always.

Top module: `byte_seq_core`

## Requirements
- R1: While reset is held and in the first cycle after it, the program counter, accumulator, general register, carry flag, illegal flag and instruction register are all zero. In that first cycle a read is issued at address 0x0000.
- R2: The port drives a read as mem_rd high with the address on mem_addr. The data returns on mem_rdata in the next cycle. A one-byte instruction takes 4 cycles, and each operand byte adds 2 cycles. The opcode is visible on ir_q 2 cycles after its read is issued. Results are visible at the end of the instruction's last cycle. Two reads are never issued in adjacent cycles.
- R3: Opcode 0x4F copies the accumulator into the general register and leaves the carry flag unchanged.
- R4: Opcode 0x37 sets the carry flag to 1.
- R5: Opcode 0xE6 reads the byte that follows it, replaces the accumulator with accumulator AND that byte, and clears the carry flag.
- R6: Opcode 0x3E reads the byte that follows it into the accumulator and leaves the carry flag unchanged.
- R7: Opcode 0x32 reads two more bytes, low byte first. In its last cycle it drives exactly one write cycle (mem_wr high) of the accumulator to that address. No other instruction writes, and a read and a write never occur in the same cycle.
- R8: Every byte read, whether opcode or operand, is taken at the current program counter, which then increments by one. The bytes of a program are therefore read at consecutive addresses.
- R9: Any other opcode is a one-byte instruction that leaves all registers unchanged. It sets the illegal flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 16 | Address for a read or a write |
| mem_wdata | output | 8 | Data for a write |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| pc_q | output | 16 | Program counter |
| ir_q | output | 8 | Instruction register |
| acc_q | output | 8 | Accumulator |
| reg_c_q | output | 8 | General register |
| carry_q | output | 1 | Carry flag |
| bad_op_q | output | 1 | Sticky illegal-opcode flag |

## Verification
Each scenario releases reset on a falling edge and counts rising edges from that point. It samples on the falling edge after a chosen number of them. A program's results are due after the sum of its instruction lengths in cycles: 4, plus 2 per operand byte. The bench checks at that exact count and, for timing claims, also one cycle earlier, to show the change has not happened yet. The instruction register is checked 2 cycles after the fetch read. The store's write is checked against a write monitor in the last cycle of the instruction and in the cycle before it.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_COPY_AC  = 8'h4F;
    localparam logic [BYTE_W-1:0] OPC_SET_CY   = 8'h37;
    localparam logic [BYTE_W-1:0] OPC_AND_IMM  = 8'hE6;
    localparam logic [BYTE_W-1:0] OPC_LOAD_IMM = 8'h3E;
    localparam logic [BYTE_W-1:0] OPC_STORE    = 8'h32;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_FETCH_WAIT,
        ST_DECODE,
        ST_OPND,
        ST_OPND_WAIT,
        ST_EXEC
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_BAD,
        OP_COPY_AC,
        OP_SET_CY,
        OP_AND_IMM,
        OP_LOAD_IMM,
        OP_STORE
    } op_kind_e;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int CNT_W      = $clog2(ADDR_BYTES + 1)
) (
    input  logic [BYTE_W-1:0] opcode,
    output op_kind_e          kind,
    output logic [CNT_W-1:0]  n_opnd
);

    always_comb begin
        case (opcode)
            OPC_COPY_AC: begin
                kind   = OP_COPY_AC;
                n_opnd = '0;
            end
            OPC_SET_CY: begin
                kind   = OP_SET_CY;
                n_opnd = '0;
            end
            OPC_AND_IMM: begin
                kind   = OP_AND_IMM;
                n_opnd = CNT_W'(1);
            end
            OPC_LOAD_IMM: begin
                kind   = OP_LOAD_IMM;
                n_opnd = CNT_W'(1);
            end
            OPC_STORE: begin
                kind   = OP_STORE;
                n_opnd = CNT_W'(ADDR_BYTES);
            end
            default: begin
                kind   = OP_BAD;
                n_opnd = '0;
            end
        endcase
    end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int CNT_W      = $clog2(ADDR_BYTES + 1),
    parameter int IDX_W      = $clog2(ADDR_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] n_opnd,
    output logic             rd_en,
    output logic             pc_inc,
    output logic             ld_ir,
    output logic             ld_opnd,
    output logic [IDX_W-1:0] opnd_idx,
    output logic             exec_en
);

    seq_state_e       state, state_nx;
    logic [CNT_W-1:0] got_q;

    // state register and operand counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH;
            got_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_DECODE) begin
                got_q <= '0;
            end else if (state == ST_OPND_WAIT) begin
                got_q <= got_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:      state_nx = ST_FETCH_WAIT;
            ST_FETCH_WAIT: state_nx = ST_DECODE;
            ST_DECODE:     state_nx = (n_opnd != '0) ? ST_OPND : ST_EXEC;
            ST_OPND:       state_nx = ST_OPND_WAIT;
            ST_OPND_WAIT:  state_nx = ((got_q + 1'b1) == n_opnd) ? ST_EXEC : ST_OPND;
            ST_EXEC:       state_nx = ST_FETCH;
            default:       state_nx = ST_FETCH;
        endcase
    end

    // outputs
    always_comb begin
        rd_en   = 1'b0;
        pc_inc  = 1'b0;
        ld_ir   = 1'b0;
        ld_opnd = 1'b0;
        exec_en = 1'b0;
        unique case (state)
            ST_FETCH, ST_OPND: begin
                rd_en  = 1'b1;
                pc_inc = 1'b1;
            end
            ST_FETCH_WAIT: ld_ir   = 1'b1;
            ST_OPND_WAIT:  ld_opnd = 1'b1;
            ST_EXEC:       exec_en = 1'b1;
            default: ;
        endcase
    end

    assign opnd_idx = got_q[IDX_W-1:0];

endmodule

// File: rtl/seq_regs.sv
module seq_regs
    import seq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int ADDR_BYTES = ADDR_W / BYTE_W,
    parameter int IDX_W      = $clog2(ADDR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rdata,
    input  logic              pc_inc,
    input  logic              ld_ir,
    input  logic              ld_opnd,
    input  logic [IDX_W-1:0]  opnd_idx,
    input  logic              exec_en,
    input  op_kind_e          kind,
    output logic [ADDR_W-1:0] pc,
    output logic [BYTE_W-1:0] ir,
    output logic [BYTE_W-1:0] acc,
    output logic [BYTE_W-1:0] reg_c,
    output logic              carry,
    output logic              bad_op,
    output logic [ADDR_W-1:0] target
);

    logic [BYTE_W-1:0] opnd [ADDR_BYTES];

    // the store address is assembled from the operand bytes, low byte first
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_tgt
        assign target[g*BYTE_W +: BYTE_W] = opnd[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ADDR_BYTES; i++) begin
                opnd[i] <= '0;
            end
        end else if (ld_opnd) begin
            opnd[opnd_idx] <= rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc     <= '0;
            ir     <= '0;
            acc    <= '0;
            reg_c  <= '0;
            carry  <= 1'b0;
            bad_op <= 1'b0;
        end else begin
            if (pc_inc) begin
                pc <= pc + 1'b1;
            end
            if (ld_ir) begin
                ir <= rdata;
            end
            if (exec_en) begin
                unique case (kind)
                    OP_COPY_AC:  reg_c <= acc;
                    OP_SET_CY:   carry <= 1'b1;
                    OP_AND_IMM: begin
                        acc   <= acc & opnd[0];
                        carry <= 1'b0;
                    end
                    OP_LOAD_IMM: acc <= opnd[0];
                    OP_STORE:    ;
                    OP_BAD:      bad_op <= 1'b1;
                    default:     ;
                endcase
            end
        end
    end

endmodule

// File: rtl/byte_seq_core.sv
module byte_seq_core
    import seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc_q,
    output logic [BYTE_W-1:0] ir_q,
    output logic [BYTE_W-1:0] acc_q,
    output logic [BYTE_W-1:0] reg_c_q,
    output logic              carry_q,
    output logic              bad_op_q
);

    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
    localparam int IDX_W      = $clog2(ADDR_BYTES);

    op_kind_e          kind;
    logic [CNT_W-1:0]  n_opnd;
    logic              rd_en, pc_inc, ld_ir, ld_opnd, exec_en;
    logic [IDX_W-1:0]  opnd_idx;
    logic [ADDR_W-1:0] target;

    seq_decode #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_dec (
        .opcode (ir_q),
        .kind   (kind),
        .n_opnd (n_opnd)
    );

    seq_fsm #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .n_opnd   (n_opnd),
        .rd_en    (rd_en),
        .pc_inc   (pc_inc),
        .ld_ir    (ld_ir),
        .ld_opnd  (ld_opnd),
        .opnd_idx (opnd_idx),
        .exec_en  (exec_en)
    );

    seq_regs #(.ADDR_W(ADDR_W), .ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rdata    (mem_rdata),
        .pc_inc   (pc_inc),
        .ld_ir    (ld_ir),
        .ld_opnd  (ld_opnd),
        .opnd_idx (opnd_idx),
        .exec_en  (exec_en),
        .kind     (kind),
        .pc       (pc_q),
        .ir       (ir_q),
        .acc      (acc_q),
        .reg_c    (reg_c_q),
        .carry    (carry_q),
        .bad_op   (bad_op_q),
        .target   (target)
    );

    assign mem_rd    = rd_en;
    assign mem_wr    = exec_en && (kind == OP_STORE);
    assign mem_addr  = mem_wr ? target : pc_q;
    assign mem_wdata = acc_q;

endmodule

// File: rtl/byte_seq_core_chk.sv
module byte_seq_core_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic [ADDR_W-1:0] pc_q,
    input logic [7:0]        ir_q,
    input logic [7:0]        acc_q,
    input logic [7:0]        reg_c_q,
    input logic              carry_q,
    input logic              bad_op_q
);

    p_rd_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    p_copy_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_c_q) |-> reg_c_q == $past(acc_q));

    p_carry_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carry_q) |-> $past(ir_q) == 8'h37);

    p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_wr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    p_wr_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_wdata == acc_q);

    p_rd_at_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> mem_addr == pc_q);

    p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> pc_q == ADDR_W'($past(pc_q) + 1'b1));

    p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd |=> $stable(pc_q));

    p_bad_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op_q |=> bad_op_q);

endmodule

bind byte_seq_core byte_seq_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc_q      (pc_q),
    .ir_q      (ir_q),
    .acc_q     (acc_q),
    .reg_c_q   (reg_c_q),
    .carry_q   (carry_q),
    .bad_op_q  (bad_op_q)
);

// File: tb/tb_byte_seq_core.sv
`timescale 1ns/1ps
module tb_byte_seq_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_addr, pc_q;
    logic [7:0]  mem_wdata, mem_rdata, ir_q, acc_q, reg_c_q;
    logic        carry_q, bad_op_q;

    logic [7:0]  mem [256];
    logic [15:0] rd_log [8];
    int          rd_n, wr_n;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    byte_seq_core dut (
        .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc_q(pc_q), .ir_q(ir_q), .acc_q(acc_q), .reg_c_q(reg_c_q),
        .carry_q(carry_q), .bad_op_q(bad_op_q)
    );

    // memory with one cycle of read latency
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    // port monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_n <= 0;
            wr_n <= 0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            if (mem_rd) begin
                if (rd_n < 8) rd_log[rd_n] <= mem_addr;
                rd_n <= rd_n + 1;
            end
            if (mem_wr) begin
                wr_n <= wr_n + 1;
                wr_addr <= mem_addr;
                wr_data <= mem_wdata;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic start(input logic [7:0] prog [], input int len);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int i = 0; i < len; i++) mem[i] = prog[i];
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
    endtask

    // advance to the falling edge after cycle n since reset release
    task automatic upto(input int n);
        while (cyc < n) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset;
        logic [7:0] p [] = '{8'h37};
        start(p, 1);
        chk_eq("R1 pc", pc_q, 0);
        chk_eq("R1 acc", acc_q, 0);
        chk_eq("R1 reg_c", reg_c_q, 0);
        chk_eq("R1 carry", carry_q, 0);
        chk_eq("R1 bad", bad_op_q, 0);
        chk_eq("R1 ir", ir_q, 0);
        chk_eq("R1 first read strobe", mem_rd, 1);
        chk_eq("R1 first read addr", mem_addr, 0);
    endtask

    task automatic t_set_carry;
        logic [7:0] p [] = '{8'h37};
        start(p, 1);
        upto(2);
        chk_eq("R2 ir after fetch", ir_q, 8'h37);
        upto(3);
        chk_eq("R2 carry not yet", carry_q, 0);
        upto(4);
        chk_eq("R4 carry set", carry_q, 1);
        chk_eq("R8 pc after 1 byte", pc_q, 1);
    endtask

    task automatic t_load_and;
        logic [7:0] p [] = '{8'h37, 8'h3E, 8'hF0, 8'hE6, 8'h3C};
        start(p, 5);
        upto(9);
        chk_eq("R2 acc not yet loaded", acc_q, 0);
        upto(10);
        chk_eq("R6 acc loaded", acc_q, 8'hF0);
        chk_eq("R6 carry kept", carry_q, 1);
        upto(16);
        chk_eq("R5 acc anded", acc_q, 8'h30);
        chk_eq("R5 carry cleared", carry_q, 0);
        chk_eq("R8 pc after 5 bytes", pc_q, 5);
    endtask

    task automatic t_copy;
        logic [7:0] p [] = '{8'h3E, 8'hA5, 8'h37, 8'h4F};
        start(p, 4);
        upto(13);
        chk_eq("R3 reg_c not yet", reg_c_q, 0);
        upto(14);
        chk_eq("R3 reg_c copied", reg_c_q, 8'hA5);
        chk_eq("R3 acc kept", acc_q, 8'hA5);
        chk_eq("R3 carry kept", carry_q, 1);
        chk_eq("R7 no write by copy", wr_n, 0);
    endtask

    task automatic t_store;
        logic [7:0] p [] = '{8'h3E, 8'h5A, 8'h32, 8'h34, 8'h12};
        start(p, 5);
        upto(13);
        chk_eq("R7 no write yet", wr_n, 0);
        upto(14);
        chk_eq("R7 one write", wr_n, 1);
        chk_eq("R7 write addr", wr_addr, 16'h1234);
        chk_eq("R7 write data", wr_data, 8'h5A);
        chk_eq("R8 read count", rd_n, 5);
        for (int k = 0; k < 5; k++) chk_eq("R8 consecutive read", rd_log[k], k);
        chk_eq("R8 pc after store", pc_q, 5);
        upto(15);
        chk_eq("R7 write not repeated", wr_n, 1);
    endtask

    task automatic t_illegal;
        logic [7:0] p [] = '{8'h3E, 8'h77, 8'hFF, 8'h37};
        start(p, 4);
        upto(9);
        chk_eq("R9 bad not yet", bad_op_q, 0);
        upto(10);
        chk_eq("R9 bad set", bad_op_q, 1);
        chk_eq("R9 acc kept", acc_q, 8'h77);
        chk_eq("R9 reg_c kept", reg_c_q, 0);
        chk_eq("R9 carry kept", carry_q, 0);
        chk_eq("R9 one byte long", pc_q, 3);
        upto(14);
        chk_eq("R9 bad sticky", bad_op_q, 1);
        chk_eq("R9 next instr runs", carry_q, 1);
        start(p, 4);
        chk_eq("R9 bad cleared by reset", bad_op_q, 0);
    endtask

    initial begin
        t_reset();
        t_set_carry();
        t_load_and();
        t_copy();
        t_store();
        t_illegal();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule